// File: doc/BRIEF.md
# Key Unwrap Sequencer

After each reset this block rebuilds a device key. It takes a stored, wrapped key word and a key word that comes from a physically unclonable function, and combines them once. When the synchronized reset releases, the sequencer samples the wrapped key and sends one request pulse to the PUF. It then waits for the PUF completion strobe and captures the PUF word on that strobe. The recovered key is the bitwise XOR of the two words. The key is presented together with a valid flag that stays high until the next reset.

A build parameter chooses the datapath. The parallel variant forms all key bits in a single step. The serial variant shifts both source words out most-significant bit first, one bit per clock, through a single XOR gate, and shifts the result bit into a key shift register. A second parameter enables a masking mode. In that mode every key-holding register is first filled from a free-running 16-bit LFSR, so the switching activity of these registers no longer follows the key data. The key output is forced to zero until the key is valid, so the masking contents never reach the port.

Top module: `key_unwrap_seq`

## Requirements
- R1: While rst_n is low, key_o, key_valid_o and puf_start_o are all zero. They clear asynchronously as soon as rst_n falls.
- R2: The release of rst_n passes through two synchronizer stages. With masking off, the wrapped key is sampled on the third rising edge after rst_n rises. puf_start_o is high for exactly the one cycle after that edge, and only once per reset.
- R3: wrapped_key_i is sampled exactly once per reset. Later changes on it do not change key_o.
- R4: puf_data_i is captured only on a rising edge where puf_done_i is high and the sequencer is waiting after its request. A completion strobe before the request or after the key is valid is ignored.
- R5: Bit i of key_o equals wrapped bit i XOR PUF bit i, for every bit.
- R6: Call the rising edge that captures the PUF word the capture edge. With SERIAL=0, key_valid_o rises on the first edge after the capture edge. With SERIAL=1, the words shift MSB first through one XOR gate, and key_valid_o rises on the KEY_W-th edge after the capture edge.
- R7: Once key_valid_o is high, it stays high and key_o holds its value until the next reset.
- R8: key_o reads zero whenever key_valid_o is low.
- R9: With RAND_RESET=1, one extra cycle fills all key registers from a 16-bit LFSR. The LFSR has a nonzero seed and advances every clock. Because of this cycle, the wrapped key is sampled on the fourth rising edge after release, and the request follows one cycle later than with masking off. The recovered key is unchanged.
- R10: A reset in any phase, including mid-shift, aborts the run. The next release starts the full sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wrapped_key_i | input | KEY_W | Stored wrapped key word |
| puf_start_o | output | 1 | One-cycle request to the PUF |
| puf_done_i | input | 1 | PUF completion strobe |
| puf_data_i | input | KEY_W | PUF key word, valid with puf_done_i |
| key_o | output | KEY_W | Recovered key, zero until valid |
| key_valid_o | output | 1 | Recovered key is valid; sticky until reset |

## Verification
A wrong sequencer state appears at the ports as a request pulse on the wrong cycle, a missing request or a repeated request. It is visible within four clocks of reset release. A datapath fault, such as a dropped shift, a wrong capture strobe or a lost XOR bit, appears as a key mismatch. It shows on the very cycle the valid flag rises, which is one clock after capture in parallel mode and KEY_W clocks after capture in serial mode. Masking contents that leak, or an early valid flag, appear as a nonzero key while the valid flag is low, on any cycle of the run.

// File: rtl/kud_pkg.sv
`timescale 1ns/1ps
package kud_pkg;
  localparam int LFSR_W = 16;

  typedef enum logic [2:0] {
    ST_SCRUB = 3'd0,
    ST_LOAD  = 3'd1,
    ST_REQ   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_COMB  = 3'd4,
    ST_SHIFT = 3'd5,
    ST_DONE  = 3'd6
  } kud_state_e;
endpackage

// File: rtl/kud_rst_sync.sv
`timescale 1ns/1ps
module kud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/kud_lfsr.sv
`timescale 1ns/1ps
module kud_lfsr #(
  parameter logic [kud_pkg::LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [kud_pkg::LFSR_W-1:0] state_o
);
  import kud_pkg::*;

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;
  logic              fb;

  // Taps 16,14,13,11: maximal length, never reaches zero from a nonzero seed
  always_comb begin
    fb     = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
    lfsr_d = {lfsr_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
    end else begin
      lfsr_q <= lfsr_d;
    end
  end

  assign state_o = lfsr_q;
endmodule

// File: rtl/kud_ctrl.sv
`timescale 1ns/1ps
module kud_ctrl #(
  parameter int KEY_W      = 8,
  parameter bit SERIAL     = 1'b0,
  parameter bit RAND_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic puf_done_i,
  output logic scrub_en_o,
  output logic load_en_o,
  output logic req_o,
  output logic cap_en_o,
  output logic step_en_o,
  output logic valid_o
);
  import kud_pkg::*;

  localparam int CNT_W = (KEY_W > 2) ? $clog2(KEY_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KEY_W - 1);
  localparam kud_state_e ST_INIT = RAND_RESET ? ST_SCRUB : ST_LOAD;

  kud_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_SCRUB: state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_REQ;
      ST_REQ:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (puf_done_i) begin
          state_d = SERIAL ? ST_SHIFT : ST_COMB;
        end
      end
      ST_COMB:  state_d = ST_DONE;
      ST_SHIFT: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_INIT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // decoded enables
  always_comb begin
    scrub_en_o = (state_q == ST_SCRUB);
    load_en_o  = (state_q == ST_LOAD);
    req_o      = (state_q == ST_REQ);
    cap_en_o   = (state_q == ST_WAIT) && puf_done_i;
    step_en_o  = (state_q == ST_COMB) || (state_q == ST_SHIFT);
    valid_o    = (state_q == ST_DONE);
  end
endmodule

// File: rtl/kud_datapath.sv
`timescale 1ns/1ps
module kud_datapath #(
  parameter int KEY_W  = 8,
  parameter bit SERIAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scrub_en_i,
  input  logic [KEY_W-1:0] scrub_val_i,
  input  logic             load_en_i,
  input  logic [KEY_W-1:0] wrapped_i,
  input  logic             cap_en_i,
  input  logic [KEY_W-1:0] puf_i,
  input  logic             step_en_i,
  output logic [KEY_W-1:0] key_q_o
);
  logic [KEY_W-1:0] wrap_q, wrap_d;
  logic [KEY_W-1:0] puf_q,  puf_d;
  logic [KEY_W-1:0] key_q,  key_d;

  generate
    if (SERIAL) begin : g_serial
      logic xor_bit;
      always_comb begin
        xor_bit = wrap_q[KEY_W-1] ^ puf_q[KEY_W-1];
        wrap_d  = wrap_q;
        puf_d   = puf_q;
        key_d   = key_q;
        if (scrub_en_i) begin
          wrap_d = scrub_val_i;
          puf_d  = ~scrub_val_i;
          key_d  = {scrub_val_i[0], scrub_val_i[KEY_W-1:1]};
        end
        if (load_en_i) begin
          wrap_d = wrapped_i;
        end
        if (cap_en_i) begin
          puf_d = puf_i;
        end
        if (step_en_i) begin
          wrap_d = {wrap_q[KEY_W-2:0], 1'b0};
          puf_d  = {puf_q[KEY_W-2:0], 1'b0};
          key_d  = {key_q[KEY_W-2:0], xor_bit};
        end
      end
    end else begin : g_parallel
      always_comb begin
        wrap_d = wrap_q;
        puf_d  = puf_q;
        key_d  = key_q;
        if (scrub_en_i) begin
          wrap_d = scrub_val_i;
          puf_d  = ~scrub_val_i;
          key_d  = {scrub_val_i[0], scrub_val_i[KEY_W-1:1]};
        end
        if (load_en_i) begin
          wrap_d = wrapped_i;
        end
        if (cap_en_i) begin
          puf_d = puf_i;
        end
        if (step_en_i) begin
          key_d = wrap_q ^ puf_q;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q <= '0;
      puf_q  <= '0;
      key_q  <= '0;
    end else begin
      wrap_q <= wrap_d;
      puf_q  <= puf_d;
      key_q  <= key_d;
    end
  end

  assign key_q_o = key_q;
endmodule

// File: rtl/key_unwrap_seq.sv
`timescale 1ns/1ps
module key_unwrap_seq #(
  parameter int                             KEY_W      = 8,
  parameter bit                             SERIAL     = 1'b0,
  parameter bit                             RAND_RESET = 1'b0,
  parameter logic [kud_pkg::LFSR_W-1:0]     LFSR_SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] wrapped_key_i,
  output logic             puf_start_o,
  input  logic             puf_done_i,
  input  logic [KEY_W-1:0] puf_data_i,
  output logic [KEY_W-1:0] key_o,
  output logic             key_valid_o
);
  import kud_pkg::*;

  logic             rst_int_n;
  logic             scrub_en, load_en, cap_en, step_en, valid;
  logic [KEY_W-1:0] scrub_val;
  logic [KEY_W-1:0] key_q;

  kud_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  generate
    if (RAND_RESET) begin : g_mask
      logic [LFSR_W-1:0] lfsr_q;
      kud_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .state_o (lfsr_q)
      );
      always_comb begin
        for (int i = 0; i < KEY_W; i++) begin
          scrub_val[i] = lfsr_q[i % LFSR_W];
        end
      end
    end else begin : g_fixed
      assign scrub_val = '0;
    end
  endgenerate

  kud_ctrl #(
    .KEY_W      (KEY_W),
    .SERIAL     (SERIAL),
    .RAND_RESET (RAND_RESET)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .puf_done_i (puf_done_i),
    .scrub_en_o (scrub_en),
    .load_en_o  (load_en),
    .req_o      (puf_start_o),
    .cap_en_o   (cap_en),
    .step_en_o  (step_en),
    .valid_o    (valid)
  );

  kud_datapath #(
    .KEY_W  (KEY_W),
    .SERIAL (SERIAL)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .scrub_en_i  (scrub_en),
    .scrub_val_i (scrub_val),
    .load_en_i   (load_en),
    .wrapped_i   (wrapped_key_i),
    .cap_en_i    (cap_en),
    .puf_i       (puf_data_i),
    .step_en_i   (step_en),
    .key_q_o     (key_q)
  );

  assign key_valid_o = valid;
  assign key_o       = valid ? key_q : '0;
endmodule

// File: rtl/kud_checker.sv
`timescale 1ns/1ps
module kud_checker #(
  parameter int KEY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             puf_start_o,
  input logic [KEY_W-1:0] key_o,
  input logic             key_valid_o
);
  logic [1:0] n_req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_req_q <= '0;
    end else if (puf_start_o && (n_req_q != 2'd3)) begin
      n_req_q <= n_req_q + 2'd1;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    puf_start_o |=> !puf_start_o); // R2
  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    n_req_q <= 2'd1); // R2
  AST_NO_START_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |-> !puf_start_o); // R4
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |=> key_valid_o); // R7
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |=> $stable(key_o)); // R7
endmodule

bind key_unwrap_seq kud_checker #(.KEY_W(KEY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .puf_start_o (puf_start_o),
  .key_o       (key_o),
  .key_valid_o (key_valid_o)
);

// File: tb/sim_key_unwrap_seq.sv
`timescale 1ns/1ps
module sim_key_unwrap_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] wrapped;
  logic       done_a  [2];
  logic [7:0] data_a  [2];
  logic       start_a [2];
  logic [7:0] key_a   [2];
  logic       valid_a [2];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  // u0: parallel, fixed reset value; u1: serial, masked reset value
  key_unwrap_seq #(.KEY_W(8), .SERIAL(1'b0), .RAND_RESET(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wrapped_key_i(wrapped),
    .puf_start_o(start_a[0]), .puf_done_i(done_a[0]), .puf_data_i(data_a[0]),
    .key_o(key_a[0]), .key_valid_o(valid_a[0]));

  key_unwrap_seq #(.KEY_W(8), .SERIAL(1'b1), .RAND_RESET(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wrapped_key_i(wrapped),
    .puf_start_o(start_a[1]), .puf_done_i(done_a[1]), .puf_data_i(data_a[1]),
    .key_o(key_a[1]), .key_valid_o(valid_a[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input logic [7:0] w, input logic [7:0] p,
                          input int dly, input int abort_at);
    bit seen  [2];
    bit fired [2];
    int st_cyc[2];
    int fire  [2];
    int nreq  [2];
    @(negedge clk);
    rst_n = 1'b0;
    wrapped = w;
    for (int k = 0; k < 2; k++) begin
      done_a[k] = 1'b0; data_a[k] = ~p;
      seen[k] = 1'b0; fired[k] = 1'b0; st_cyc[k] = 0; fire[k] = 0; nreq[k] = 0;
    end
    #1;
    for (int k = 0; k < 2; k++) begin
      chk({valid_a[k], key_a[k], start_a[k]} == 10'd0, "R1 R10 async clear",
          {valid_a[k], key_a[k], start_a[k]}, 0);
    end
    repeat (2) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk({valid_a[k], key_a[k], start_a[k]} == 10'd0, "R1 held in reset",
          {valid_a[k], key_a[k], start_a[k]}, 0);
    end
    rst_n = 1'b1;
    for (int c = 1; c <= 32; c++) begin
      @(negedge clk);
      if (abort_at != 0 && c == abort_at) return;
      if (c == 5) wrapped = ~w;  // R3: change after both samples
      for (int k = 0; k < 2; k++) begin
        int exp_st;
        int lat;
        exp_st = (k == 0) ? 3 : 4;
        lat    = (k == 0) ? 1 : 8;
        // observe
        if (start_a[k]) begin
          nreq[k]++;
          if (!seen[k]) begin
            seen[k] = 1'b1;
            st_cyc[k] = c;
            chk(c == exp_st, (k == 0) ? "R2 request cycle" : "R9 request cycle", c, exp_st);
          end
        end
        if (!valid_a[k]) chk(key_a[k] == 8'h00, "R8 key zero while invalid", key_a[k], 0);
        if (fired[k]) begin
          if (c == fire[k] + lat) chk(valid_a[k] == 1'b0, "R6 valid too early", valid_a[k], 0);
          if (c == fire[k] + lat + 1) begin
            chk(valid_a[k] == 1'b1, "R6 valid rise", valid_a[k], 1);
            chk(key_a[k] == (w ^ p), "R3 R4 R5 key value", key_a[k], w ^ p);
          end
          if (c > fire[k] + lat + 1)
            chk(valid_a[k] && key_a[k] == (w ^ p), "R7 R4 key held",
                {valid_a[k], key_a[k]}, {1'b1, w ^ p});
        end
        // drive PUF model
        if (!fired[k] && seen[k] && c == st_cyc[k] + dly) begin
          done_a[k] = 1'b1; data_a[k] = p; fired[k] = 1'b1; fire[k] = c;
        end else if (c == 2) begin
          done_a[k] = 1'b1; data_a[k] = ~p;          // R4: before request
        end else if (fired[k] && c == fire[k] + lat + 3) begin
          done_a[k] = 1'b1; data_a[k] = p ^ 8'h5A;   // R4: after valid
        end else begin
          done_a[k] = 1'b0; data_a[k] = ~p;
        end
      end
    end
    for (int k = 0; k < 2; k++) begin
      chk(nreq[k] == 1, "R2 single request", nreq[k], 1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    wrapped = 8'h00;
    for (int k = 0; k < 2; k++) begin
      done_a[k] = 1'b0; data_a[k] = 8'h00;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      run_case(8'(i), 8'((i * 37 + 11) & 255), 1 + (i % 4), 0);
    end
    for (int i = 0; i < 256; i++) begin
      run_case(8'hC3, 8'(i), 1 + (i % 3), 0);
    end
    // R10: abort in various phases, then a full run must follow
    for (int i = 0; i < 10; i++) begin
      run_case(8'(8'h5A + i), 8'(8'hA5 - i), 2, 3 + 2 * i);
      run_case(8'(8'h0F + i), 8'(8'hF0 + i), 1, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule